// File: doc/BRIEF.md
# Real-Time Counter and Watchdog with Shared Prescaler

This block holds an 8-bit real-time counter and a watchdog timer that take turns using one 8-bit programmable prescaler. A mode register picks which of the two owns the prescaler, the divide ratio, whether the counter follows the instruction-cycle strobe or an external pin, and which pin edge counts. The counter raises a sticky overflow flag each time it wraps from all ones to zero. The watchdog counts a slow tick and issues a one-cycle reset request when its count wraps. A clear command or a sleep entry restarts it.

Software reaches the block through two write ports, one for the mode register and one for the counter, and a flag-clear strobe. The external pin passes through a two-flop synchronizer before edge detection. The caller delivers the watchdog tick and the instruction-cycle strobe as single-cycle enables in the block's clock domain. `rst_n` is asynchronous active-low and is expected to be released in step with `clk`.

Top module: `rtc_wdt_top`

## Requirements
- R1: After reset, `mode_q` reads 8'hFF and `cnt_value`, `ovf_flag` and `wdt_reset` are 0. The watchdog count and the prescaler count are also zero.
- R2: Mode bit 5 picks the counter source. 0 counts cycles with `cyc_stb` high. 1 counts selected edges of `ext_pin`, and with 1 set, `cyc_stb` has no effect on the counter.
- R3: Mode bit 4 picks the pin edge: 0 counts rising edges of `ext_pin`, 1 counts falling edges. A pin change driven before clock edge k shows in `cnt_value` after edge k+2.
- R4: With mode bit 3 = 0, the prescaler belongs to the counter. Ratio code n in mode bits 2:0 makes the counter advance once per 2^(n+1) source events: code 0 gives 1:2 and code 7 gives 1:256. The watchdog then advances on every tick.
- R5: With mode bit 3 = 1, the counter advances on every source event. Each watchdog step then needs 2^n ticks, so code 0 gives 1:1.
- R6: An increment from all ones to zero sets `ovf_flag` on the same clock edge. `flag_clr` clears the flag, and a set in the same cycle wins over the clear.
- R7: `cnt_we` loads `cnt_wdata` into the counter and takes precedence over an increment in the same cycle. While the prescaler belongs to the counter, the write also zeroes the prescaler.
- R8: The watchdog advances a WDT_W-bit count by one per watchdog step. The step that wraps the count from all ones to zero drives `wdt_reset` high for exactly one cycle, starting at the next edge.
- R9: `wdt_clr` or `sleep_req` zeroes the watchdog count and overrides a step in the same cycle. While the prescaler belongs to the watchdog, either one also zeroes the prescaler.
- R10: `mode_we` loads `mode_wdata` into the mode register, visible on `mode_q` after the edge. The new settings govern counting from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Instruction-cycle strobe, internal count source |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Slow watchdog time base, one-cycle pulses |
| wdt_clr | input | 1 | Watchdog clear command |
| sleep_req | input | 1 | Sleep entry, also clears the watchdog |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 8 | Mode register write data |
| mode_q | output | 8 | Current mode register |
| cnt_we | input | 1 | Counter write enable |
| cnt_wdata | input | CNT_W | Counter write data |
| cnt_value | output | CNT_W | Current counter value |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| wdt_reset | output | 1 | One-cycle watchdog timeout request |

## Verification
Several properties are checked on every cycle:
- a counter write lands exactly;
- the counter moves by at most one per cycle and stays still when the internal source is idle;
- a wrap to zero always leaves the flag set;
- a watchdog clear always suppresses a timeout in the next cycle, and a timeout lasts one cycle;
- a mode write lands.

Only the bench's scenarios can show the following, by comparing against a behavioural model on each clock and by directed counts:
- the exact divide ratios in both prescaler assignments and the pin-edge polarity;
- the two-cycle synchronizer delay;
- the prescaler reset on writes and clears;
- the full watchdog period.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  // Mode register layout; field positions are decoded by the top module.
  typedef struct packed {
    logic [1:0] spare;     // 7:6 plain storage
    logic       src_ext;   // 5   1 = external pin edges
    logic       edge_fall; // 4   1 = falling edge
    logic       pre_wdt;   // 3   1 = prescaler to watchdog
    logic [2:0] ratio;     // 2:0 divide code
  } rtcw_mode_t;

  localparam logic [7:0] MODE_RST = 8'hFF;
endpackage

// File: rtl/rtcw_pin_sync.sv
module rtcw_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic            now_lvl, old_lvl;

  always_comb sh_d = {sh_q[SH_W-2:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign now_lvl = sh_q[SYNC_STAGES-1];
  assign old_lvl = sh_q[SYNC_STAGES];
  assign edge_o  = fall_sel_i ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
endmodule

// File: rtl/rtcw_prescaler.sv
module rtcw_prescaler #(
  parameter int PRE_W = 8,
  localparam int TAP_W = $clog2(PRE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             clr_i,
  input  logic [TAP_W-1:0] taps_i,
  output logic             pass_o
);
  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(taps_i));
  end

  // An event passes once the low taps_i bits are all ones.
  assign pass_o = ev_i && ((pre_q & mask) == mask);

  always_comb begin
    pre_d = pre_q;
    if (clr_i)     pre_d = '0;
    else if (ev_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/rtcw_wdt.sv
module rtcw_wdt #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic clr_i,
  output logic timeout_o
);
  logic [WDT_W-1:0] wcnt_q, wcnt_d;
  logic             to_q, to_d;

  always_comb begin
    wcnt_d = wcnt_q;
    to_d   = 1'b0;
    if (clr_i) begin
      wcnt_d = '0;
    end else if (ev_i) begin
      wcnt_d = wcnt_q + 1'b1;
      to_d   = (wcnt_q == {WDT_W{1'b1}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      to_q   <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      to_q   <= to_d;
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/rtc_wdt_top.sv
module rtc_wdt_top
  import rtcw_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  input  logic             sleep_req,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  output logic [7:0]       mode_q,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_value,
  input  logic             flag_clr,
  output logic             ovf_flag,
  output logic             wdt_reset
);
  localparam int TAP_W = $clog2(PRE_W + 1);

  rtcw_mode_t       mode_r, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d, wrap;
  logic             ext_ev, src_ev, pre_ev, pre_clr, pre_pass;
  logic             cnt_ev, wdt_ev, wdt_kill;
  logic [TAP_W-1:0] taps;

  // Mode register
  always_comb mode_d = mode_we ? rtcw_mode_t'(mode_wdata) : mode_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_r <= rtcw_mode_t'(MODE_RST);
    else        mode_r <= mode_d;
  end

  // Pin path and source select
  rtcw_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_pin),
    .fall_sel_i (mode_r.edge_fall),
    .edge_o     (ext_ev)
  );

  assign src_ev   = mode_r.src_ext ? ext_ev : cyc_stb;
  assign wdt_kill = wdt_clr | sleep_req;

  // Prescaler routing: the counter's table sits one power of two above the watchdog's.
  assign taps    = mode_r.pre_wdt ? TAP_W'(mode_r.ratio) : TAP_W'(mode_r.ratio) + TAP_W'(1);
  assign pre_ev  = mode_r.pre_wdt ? wdt_tick : src_ev;
  assign pre_clr = mode_r.pre_wdt ? wdt_kill : cnt_we;
  assign cnt_ev  = mode_r.pre_wdt ? src_ev   : pre_pass;
  assign wdt_ev  = mode_r.pre_wdt ? pre_pass : wdt_tick;

  rtcw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (pre_ev),
    .clr_i  (pre_clr),
    .taps_i (taps),
    .pass_o (pre_pass)
  );

  // Counter and overflow flag
  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (cnt_we) begin
      cnt_d = cnt_wdata;
    end else if (cnt_ev) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = (cnt_q == {CNT_W{1'b1}});
    end
    flag_d = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  // Watchdog
  rtcw_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (wdt_ev),
    .clr_i     (wdt_kill),
    .timeout_o (wdt_reset)
  );

  assign mode_q    = mode_r;
  assign cnt_value = cnt_q;
  assign ovf_flag  = flag_q;
endmodule

// File: rtl/rtcw_checker.sv
module rtcw_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_stb,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             mode_we,
  input logic [7:0]       mode_wdata,
  input logic             wdt_clr,
  input logic             sleep_req,
  input logic [CNT_W-1:0] cnt_value,
  input logic             ovf_flag,
  input logic             wdt_reset,
  input logic [7:0]       mode_q
);
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_value == $past(cnt_wdata)); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_value == $past(cnt_value)) || (cnt_value == CNT_W'($past(cnt_value) + 1'b1))); // R4

  AST_INT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[5] && !cyc_stb && !cnt_we) |=> $stable(cnt_value)); // R2

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && cnt_value == {CNT_W{1'b1}}) ##1 (cnt_value == '0) |-> ovf_flag); // R6

  AST_WDT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset); // R8

  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr || sleep_req) |=> !wdt_reset); // R9

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_q == $past(mode_wdata)); // R10
endmodule

bind rtc_wdt_top rtcw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_stb    (cyc_stb),
  .cnt_we     (cnt_we),
  .cnt_wdata  (cnt_wdata),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .wdt_clr    (wdt_clr),
  .sleep_req  (sleep_req),
  .cnt_value  (cnt_value),
  .ovf_flag   (ovf_flag),
  .wdt_reset  (wdt_reset),
  .mode_q     (mode_q)
);

// File: tb/rtc_wdt_top_test.sv
`timescale 1ns/1ps
module rtc_wdt_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_stb, ext_pin, wdt_tick, wdt_clr, sleep_req;
  logic       mode_we, cnt_we, flag_clr;
  logic [7:0] mode_wdata, cnt_wdata;
  logic [7:0] mode_q, cnt_value;
  logic       ovf_flag, wdt_reset;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase_req = "R1";

  always #2 clk = ~clk;

  rtc_wdt_top uut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .sleep_req(sleep_req),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_q(mode_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .wdt_reset(wdt_reset)
  );

  // Behavioural reference model, updated on each rising edge.
  int m_mode, m_pre, m_cnt, m_flag, m_w, m_to;
  bit p0, p1, p2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 255; m_pre = 0; m_cnt = 0; m_flag = 0; m_w = 0; m_to = 0;
      p0 = 0; p1 = 0; p2 = 0;
    end else begin
      bit to_w, ext, src, pev, pass, pclr, cev, wev, kill;
      int k, div;
      to_w = m_mode[3];
      k    = m_mode % 8 + (to_w ? 0 : 1);
      div  = 1 << k;
      ext  = m_mode[4] ? (p2 && !p1) : (p1 && !p2);
      src  = m_mode[5] ? ext : cyc_stb;
      kill = wdt_clr || sleep_req;
      pev  = to_w ? wdt_tick : src;
      pass = pev && ((m_pre % div) == div - 1);
      pclr = to_w ? kill : cnt_we;
      cev  = to_w ? src : pass;
      wev  = to_w ? pass : wdt_tick;
      if (cnt_we) m_cnt = cnt_wdata;
      else if (cev) begin
        if (m_cnt == 255) begin m_cnt = 0; m_flag = 1; end
        else begin m_cnt++; if (flag_clr) m_flag = 0; end
      end else if (flag_clr) m_flag = 0;
      if (cnt_we && flag_clr) m_flag = 0;
      m_to = 0;
      if (kill) m_w = 0;
      else if (wev) begin
        if (m_w == 255) begin m_w = 0; m_to = 1; end else m_w++;
      end
      if (pclr) m_pre = 0; else if (pev) m_pre = (m_pre + 1) % 256;
      if (mode_we) m_mode = mode_wdata;
      p2 = p1; p1 = p0; p0 = ext_pin;
    end
  end

  // Per-cycle comparison, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(cnt_value) != m_cnt || int'(ovf_flag) != m_flag ||
          int'(wdt_reset) != m_to || int'(mode_q) != m_mode) begin
        errors++;
        $display("FAIL %s model: cnt=%0d flag=%0d to=%0d mode=%0h expected cnt=%0d flag=%0d to=%0d mode=%0h",
                 phase_req, cnt_value, ovf_flag, wdt_reset, mode_q, m_cnt, m_flag, m_to, m_mode);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_we = 1; mode_wdata = v; @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1; cnt_wdata = v; @(negedge clk); cnt_we = 0;
  endtask

  task automatic strobes(input int n);
    repeat (n) begin cyc_stb = 1; @(negedge clk); cyc_stb = 0; @(negedge clk); end
  endtask

  task automatic pin_pulses(input int n);
    repeat (n) begin ext_pin = 1; cyc(3); ext_pin = 0; cyc(3); end
  endtask

  task automatic ticks(input int n);
    wdt_tick = 1; cyc(n); wdt_tick = 0;
  endtask

  task automatic kick;
    wdt_clr = 1; @(negedge clk); wdt_clr = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; cyc_stb = 0; ext_pin = 0; wdt_tick = 0; wdt_clr = 0; sleep_req = 0;
    mode_we = 0; cnt_we = 0; flag_clr = 0; mode_wdata = 0; cnt_wdata = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk(mode_q == 8'hFF, "R1", mode_q, 255);
    chk(cnt_value == 0, "R1", cnt_value, 0);
    chk(ovf_flag == 0 && wdt_reset == 0, "R1", ovf_flag, 0);

    // R4 counter prescale ratios
    phase_req = "R4";
    wr_mode(8'h00); wr_cnt(8'h00); strobes(10);
    chk(cnt_value == 5, "R4", cnt_value, 5);
    wr_mode(8'h02); wr_cnt(8'h00); strobes(32);
    chk(cnt_value == 4, "R4", cnt_value, 4);
    wr_mode(8'h07); wr_cnt(8'h00); strobes(512);
    chk(cnt_value == 2, "R4", cnt_value, 2);

    // R5 no division when the watchdog owns the prescaler
    phase_req = "R5";
    wr_mode(8'h08); wr_cnt(8'h10); strobes(7);
    chk(cnt_value == 8'h17, "R5", cnt_value, 8'h17);

    // R2 external source ignores the strobe; R3 rising edges
    phase_req = "R2";
    wr_mode(8'h28); wr_cnt(8'h00); strobes(5);
    chk(cnt_value == 0, "R2", cnt_value, 0);
    phase_req = "R3";
    pin_pulses(4);
    chk(cnt_value == 4, "R3", cnt_value, 4);
    // R3 falling edges and synchronizer latency
    wr_mode(8'h38); wr_cnt(8'h00);
    ext_pin = 1; cyc(4);
    chk(cnt_value == 0, "R3", cnt_value, 0);
    ext_pin = 0; cyc(2);
    chk(cnt_value == 0, "R3", cnt_value, 0);
    cyc(1);
    chk(cnt_value == 1, "R3", cnt_value, 1);

    // R6 overflow flag
    phase_req = "R6";
    wr_mode(8'h08); wr_cnt(8'hFE); strobes(1);
    chk(cnt_value == 8'hFF && ovf_flag == 0, "R6", ovf_flag, 0);
    strobes(1);
    chk(cnt_value == 0 && ovf_flag == 1, "R6", ovf_flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk(ovf_flag == 0, "R6", ovf_flag, 0);
    wr_cnt(8'hFF);
    cyc_stb = 1; flag_clr = 1; cyc(1); cyc_stb = 0; flag_clr = 0;
    chk(ovf_flag == 1, "R6", ovf_flag, 1);

    // R7 counter write priority and prescaler clear
    phase_req = "R7";
    wr_mode(8'h00); wr_cnt(8'h00); strobes(1);
    wr_cnt(8'h40); strobes(1);
    chk(cnt_value == 8'h40, "R7", cnt_value, 8'h40);
    strobes(1);
    chk(cnt_value == 8'h41, "R7", cnt_value, 8'h41);
    wr_mode(8'h08);
    cyc_stb = 1; cnt_we = 1; cnt_wdata = 8'h80; cyc(1); cyc_stb = 0; cnt_we = 0;
    chk(cnt_value == 8'h80, "R7", cnt_value, 8'h80);

    // R8 watchdog timeout at 1:1
    phase_req = "R8";
    kick(); ticks(255);
    chk(wdt_reset == 0, "R8", wdt_reset, 0);
    ticks(1);
    chk(wdt_reset == 1, "R8", wdt_reset, 1);
    cyc(1);
    chk(wdt_reset == 0, "R8", wdt_reset, 0);
    // R5 watchdog 1:2
    phase_req = "R5";
    wr_mode(8'h09); kick(); ticks(511);
    chk(wdt_reset == 0, "R5", wdt_reset, 0);
    ticks(1);
    chk(wdt_reset == 1, "R5", wdt_reset, 1);
    // R4 watchdog undivided when the counter owns the prescaler
    phase_req = "R4";
    wr_mode(8'h07); kick(); ticks(256);
    chk(wdt_reset == 1, "R4", wdt_reset, 1);

    // R9 sleep entry restarts the watchdog and beats a tick
    phase_req = "R9";
    wr_mode(8'h08); kick();
    wdt_tick = 1; cyc(200);
    sleep_req = 1; cyc(1); sleep_req = 0;
    cyc(255);
    chk(wdt_reset == 0, "R9", wdt_reset, 0);
    cyc(1); wdt_tick = 0;
    chk(wdt_reset == 1, "R9", wdt_reset, 1);

    // R10 mode write
    phase_req = "R10";
    wr_mode(8'h5A);
    chk(mode_q == 8'h5A, "R10", mode_q, 8'h5A);
    cyc(2);
    finish_run();
  end
endmodule